// File: doc/BRIEF.md
# Handshake-Driven Microinstruction Sequencer

This block is the control unit of a small accumulator processor. It does not move data. It produces the one-cycle activation strobes that tell the datapath which register to load, which transfer to enable and when to clock the memory. Control runs on a fast sampling clock, but the order of the strobes is not set by a state counter. It comes from chains of control stages that pass a token to each other through four-phase request/acknowledge handshakes. Each stage fires its own strobe and then holds the token for a programmable settle time before passing it on.

A selector runs the instruction cycle. It first requests the fetch chain, which has four stages, and waits for that chain's completion. It then decodes the opcode and requests one of five execution chains, each of a different length. It waits for that chain's completion before it requests fetch again. An opcode that selects no chain sends control straight back to fetch. Two markers show the start of each fetch phase and each execute phase, so that software tools or a logic analyser can measure phase lengths.

Top module: `ustep_sequencer`

## Requirements
- R1: After start, every instruction begins with four fetch strobes in order: bit 0 (program counter to address register), bit 1 (clock address register), bit 2 (clock memory), bit 3 (clock instruction register).
- R2: Opcode values 1 to 5 select execution chains 1 to 5. Execution strobes appear only after the last fetch strobe, and the next fetch begins only after the selected chain has signalled completion.
- R3: Between stages, a request stays high until it is acknowledged, and an acknowledge falls only after its request has fallen (four-phase return to zero).
- R4: Chain 1 (opcode 1) fires bit 4 (complement accumulator) and then bit 5 (clock accumulator).
- R5: Chain 2 (opcode 2) fires bit 6 (clock output port). Chain 3 (opcode 3) fires bit 7 (shift accumulator left), bit 5, then bit 8 (clock carry flag).
- R6: Chain 4 (opcode 4, direct load) fires in order: bit 9 (register to address register), 1, 2, bit 10 (memory to register), bit 11 (clock register), bit 12 (settle wait), bit 13 (register to accumulator), 5.
- R7: Chain 5 (opcode 5, subroutine call) fires in order: 9, 1, bit 14 (program counter to register), 11, bit 15 (address register to program counter), bit 16 (clock program counter), bit 17 (memory write), 2, bit 18 (increment program counter), 16.
- R8: A stage with settle delay d is followed by the next strobe of its chain exactly max(d,1)+1 cycles later. A delay of 0 acts as 1.
- R9: Opcodes 0 and 6 to 15 produce no execution strobe and no execute marker. The next fetch marker follows directly.
- R10: fetch_start and exec_start are single-cycle pulses, each exactly one cycle before the first strobe of its phase. exec_start occurs once per mapped instruction.
- R11: At most one strobe bit is high in any cycle.
- R12: While reset is high, and afterwards until start is sampled high, all strobes and markers stay low.
- R13: The opcode is sampled once per instruction, after fetch completes. A change after exec_start does not alter the running chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the fetch/execute alternation when sampled high in idle |
| opcode | input | OP_W | Instruction code, sampled after each fetch |
| strobe | output | NUM_STB | Registered microoperation strobes, one bit per operation |
| fetch_start | output | 1 | One-cycle marker of a fetch phase |
| exec_start | output | 1 | One-cycle marker of an execute phase |

## Verification
Two things can fall in the same cycle. The first is the return-to-zero of an execution chain's last handshake, which meets the selector raising the next fetch request and marker. The second is an opcode change, which lands on the same cycle as the execute marker. The first is provoked by giving the final stages a settle delay of 0. Every opcode is run back to back, including repeats of the same chain, so that a chain is requested again soon after it finishes. The bench judges the outcome at the ports: the order of the strobes, the distance between them and the offset of each marker must match the values computed from the delay table. The second is provoked by switching the opcode to a different mapped value in the exec_start cycle. The bench then requires the original chain's strobe sequence, unchanged.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int NUM_STB   = 19;
  localparam int NUM_EXEC  = 5;
  localparam int MAX_LEN   = 10;
  localparam int FETCH_LEN = 4;

  localparam int SB_PC_MAR   = 0;
  localparam int SB_MAR_CLK  = 1;
  localparam int SB_RAM_CLK  = 2;
  localparam int SB_IR_CLK   = 3;
  localparam int SB_CPL_ACC  = 4;
  localparam int SB_ACC_CLK  = 5;
  localparam int SB_PORT_CLK = 6;
  localparam int SB_SHL_ACC  = 7;
  localparam int SB_FLAG_CLK = 8;
  localparam int SB_REG_MAR  = 9;
  localparam int SB_MEM_REG  = 10;
  localparam int SB_REG_CLK  = 11;
  localparam int SB_SETTLE   = 12;
  localparam int SB_REG_ACC  = 13;
  localparam int SB_PC_REG   = 14;
  localparam int SB_MAR_PC   = 15;
  localparam int SB_PC_CLK   = 16;
  localparam int SB_RAM_WR   = 17;
  localparam int SB_PC_INC   = 18;

  // chain 0 is fetch, 1..NUM_EXEC are execution chains
  function automatic int chain_len(input int c);
    case (c)
      0: return FETCH_LEN;
      1: return 2;
      2: return 1;
      3: return 3;
      4: return 8;
      5: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic int stb_of(input int c, input int s);
    case (c)
      0: return s;
      1: return (s == 0) ? SB_CPL_ACC : SB_ACC_CLK;
      2: return SB_PORT_CLK;
      3: case (s)
           0: return SB_SHL_ACC;
           1: return SB_ACC_CLK;
           default: return SB_FLAG_CLK;
         endcase
      4: case (s)
           0: return SB_REG_MAR;
           1: return SB_MAR_CLK;
           2: return SB_RAM_CLK;
           3: return SB_MEM_REG;
           4: return SB_REG_CLK;
           5: return SB_SETTLE;
           6: return SB_REG_ACC;
           default: return SB_ACC_CLK;
         endcase
      5: case (s)
           0: return SB_REG_MAR;
           1: return SB_MAR_CLK;
           2: return SB_PC_REG;
           3: return SB_REG_CLK;
           4: return SB_MAR_PC;
           5: return SB_PC_CLK;
           6: return SB_RAM_WR;
           7: return SB_RAM_CLK;
           8: return SB_PC_INC;
           default: return SB_PC_CLK;
         endcase
      default: return 0;
    endcase
  endfunction

  // 0 means the opcode selects no execution chain
  function automatic int chain_of(input int op);
    return (op >= 1 && op <= NUM_EXEC) ? op : 0;
  endfunction
endpackage

// File: rtl/ustep_stage.sv
module ustep_stage #(
  parameter int DLY_W = 4,
  parameter logic [DLY_W-1:0] DLY = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  output logic ack_out,
  output logic req_out,
  input  logic ack_in,
  output logic fire
);
  localparam logic [DLY_W-1:0] DEFF = (DLY == '0) ? DLY_W'(1) : DLY;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HS} st_t;
  st_t st_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      req_out <= 1'b0;
      ack_out <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_in) begin
          fire  <= 1'b1;
          cnt_q <= DEFF - DLY_W'(1);
          st_q  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            req_out <= 1'b1;
            ack_out <= 1'b1;
            st_q    <= ST_HS;
          end else begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        default: begin
          if (!req_in) ack_out <= 1'b0;
          if (ack_in)  req_out <= 1'b0;
          if (!req_out && !ack_in && !ack_out) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  AST_REQ_HELD_TO_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(req_out) |-> $past(ack_in)); // R3
  AST_ACK_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_out) |-> !$past(req_in)); // R3
  AST_FIRE_ON_REQUEST: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(req_in)); // R3
endmodule

// File: rtl/ustep_chain.sv
module ustep_chain #(
  parameter int N = 2,
  parameter int DLY_W = 4,
  parameter logic [N*DLY_W-1:0] DLYS = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_in,
  output logic         ack_out,
  output logic         done_req,
  input  logic         done_ack,
  output logic [N-1:0] fire
);
  logic [N:0] req;
  logic [N:0] ack;

  assign req[0]   = req_in;
  assign ack_out  = ack[0];
  assign done_req = req[N];
  assign ack[N]   = done_ack;

  for (genvar i = 0; i < N; i++) begin : g_stage
    ustep_stage #(
      .DLY_W (DLY_W),
      .DLY   (DLYS[i*DLY_W +: DLY_W])
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .req_in  (req[i]),
      .ack_out (ack[i]),
      .req_out (req[i+1]),
      .ack_in  (ack[i+1]),
      .fire    (fire[i])
    );
  end

  AST_CHAIN_ONE_FIRE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fire)); // R11
endmodule

// File: rtl/ustep_select.sv
module ustep_select import ustep_pkg::*; #(
  parameter int OP_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [OP_W-1:0]     opcode,
  output logic                f_req,
  input  logic                f_ack,
  input  logic                f_done,
  output logic                f_dack,
  output logic [NUM_EXEC-1:0] x_req,
  input  logic [NUM_EXEC-1:0] x_ack,
  input  logic [NUM_EXEC-1:0] x_done,
  output logic [NUM_EXEC-1:0] x_dack,
  output logic                fmark,
  output logic                xmark
);
  localparam int SEL_W = $clog2(NUM_EXEC);

  typedef enum logic [2:0] {
    SL_IDLE, SL_F_REQ, SL_F_WAIT, SL_F_ACK,
    SL_DEC, SL_X_REQ, SL_X_WAIT, SL_X_ACK
  } sl_t;

  sl_t              st_q;
  logic [SEL_W-1:0] sel_q;
  int               dec_ch;

  always_comb dec_ch = chain_of(int'(opcode));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SL_IDLE;
      sel_q  <= '0;
      f_req  <= 1'b0;
      f_dack <= 1'b0;
      x_req  <= '0;
      x_dack <= '0;
      fmark  <= 1'b0;
      xmark  <= 1'b0;
    end else begin
      fmark <= 1'b0;
      xmark <= 1'b0;
      case (st_q)
        SL_IDLE: if (start) begin
          f_req <= 1'b1;
          fmark <= 1'b1;
          st_q  <= SL_F_REQ;
        end
        SL_F_REQ: if (f_ack) begin
          f_req <= 1'b0;
          st_q  <= SL_F_WAIT;
        end
        SL_F_WAIT: if (f_done) begin
          f_dack <= 1'b1;
          st_q   <= SL_F_ACK;
        end
        SL_F_ACK: if (!f_done) begin
          f_dack <= 1'b0;
          st_q   <= SL_DEC;
        end
        SL_DEC: begin
          if (dec_ch != 0) begin
            sel_q <= SEL_W'(dec_ch - 1);
            x_req <= NUM_EXEC'(1) << (dec_ch - 1);
            xmark <= 1'b1;
            st_q  <= SL_X_REQ;
          end else begin
            f_req <= 1'b1;
            fmark <= 1'b1;
            st_q  <= SL_F_REQ;
          end
        end
        SL_X_REQ: if (x_ack[sel_q]) begin
          x_req <= '0;
          st_q  <= SL_X_WAIT;
        end
        SL_X_WAIT: if (x_done[sel_q]) begin
          x_dack[sel_q] <= 1'b1;
          st_q          <= SL_X_ACK;
        end
        default: if (!x_done[sel_q]) begin
          x_dack <= '0;
          f_req  <= 1'b1;
          fmark  <= 1'b1;
          st_q   <= SL_F_REQ;
        end
      endcase
    end
  end

  AST_SINGLE_CHAIN_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({f_req, x_req})); // R2
  AST_FETCH_AFTER_COMPLETION: assert property (@(posedge clk) disable iff (rst)
    $rose(f_req) |-> (x_done == '0)); // R2
  AST_EXEC_ONLY_MAPPED: assert property (@(posedge clk) disable iff (rst)
    xmark |-> ($past(chain_of(int'(opcode))) != 0)); // R9
endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer import ustep_pkg::*; #(
  parameter int OP_W  = 4,
  parameter int DLY_W = 4,
  parameter logic [FETCH_LEN*DLY_W-1:0] FETCH_DLY = 16'h1201,
  parameter logic [NUM_EXEC*MAX_LEN*DLY_W-1:0] EXEC_DLY = {
    40'h0131211111, 40'h0001511311, 40'h0000000210,
    40'h0000000003, 40'h0000000021}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [OP_W-1:0]    opcode,
  output logic [NUM_STB-1:0] strobe,
  output logic               fetch_start,
  output logic               exec_start
);
  localparam int SLOT_W = MAX_LEN * DLY_W;

  logic                f_req, f_ack, f_done, f_dack;
  logic [NUM_EXEC-1:0] x_req, x_ack, x_done, x_dack;
  logic                fmark, xmark;
  logic [NUM_EXEC:0][MAX_LEN-1:0] fire_all;
  logic [NUM_STB-1:0]  stb_d;

  ustep_select #(.OP_W(OP_W)) u_select (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opcode (opcode),
    .f_req  (f_req),
    .f_ack  (f_ack),
    .f_done (f_done),
    .f_dack (f_dack),
    .x_req  (x_req),
    .x_ack  (x_ack),
    .x_done (x_done),
    .x_dack (x_dack),
    .fmark  (fmark),
    .xmark  (xmark)
  );

  ustep_chain #(
    .N     (FETCH_LEN),
    .DLY_W (DLY_W),
    .DLYS  (FETCH_DLY)
  ) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .req_in   (f_req),
    .ack_out  (f_ack),
    .done_req (f_done),
    .done_ack (f_dack),
    .fire     (fire_all[0][FETCH_LEN-1:0])
  );
  if (FETCH_LEN < MAX_LEN) begin : g_fetch_pad
    assign fire_all[0][MAX_LEN-1:FETCH_LEN] = '0;
  end

  for (genvar c = 1; c <= NUM_EXEC; c++) begin : g_exec
    localparam int LEN = chain_len(c);
    ustep_chain #(
      .N     (LEN),
      .DLY_W (DLY_W),
      .DLYS  (EXEC_DLY[(c-1)*SLOT_W +: LEN*DLY_W])
    ) u_chain (
      .clk      (clk),
      .rst      (rst),
      .req_in   (x_req[c-1]),
      .ack_out  (x_ack[c-1]),
      .done_req (x_done[c-1]),
      .done_ack (x_dack[c-1]),
      .fire     (fire_all[c][LEN-1:0])
    );
    if (LEN < MAX_LEN) begin : g_pad
      assign fire_all[c][MAX_LEN-1:LEN] = '0;
    end
  end

  // several chains share a strobe, so their stage fires are merged by OR
  always_comb begin
    stb_d = '0;
    for (int c = 0; c <= NUM_EXEC; c++) begin
      for (int s = 0; s < MAX_LEN; s++) begin
        if (s < chain_len(c)) stb_d[stb_of(c, s)] = stb_d[stb_of(c, s)] | fire_all[c][s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe      <= '0;
      fetch_start <= 1'b0;
      exec_start  <= 1'b0;
    end else begin
      strobe      <= stb_d;
      fetch_start <= fmark;
      exec_start  <= xmark;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe)); // R11
  AST_FETCH_MARK_LEADS: assert property (@(posedge clk) disable iff (rst)
    fetch_start |=> (strobe == NUM_STB'(1))); // R10
  AST_EXEC_MARK_LEADS: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> ($countones(strobe) == 1)); // R10
  AST_FETCH_MARK_PULSE: assert property (@(posedge clk) disable iff (rst)
    fetch_start |=> !fetch_start); // R10
endmodule

// File: tb/tb_ustep_sequencer.sv
module tb_ustep_sequencer;
  localparam int OP_W = 4;
  localparam int NSTB = 19;

  localparam int EXP_LEN [6] = '{4, 2, 1, 3, 8, 10};
  localparam int EXP_ID [6][10] = '{
    '{0, 1, 2, 3, 0, 0, 0, 0, 0, 0},
    '{4, 5, 0, 0, 0, 0, 0, 0, 0, 0},
    '{6, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{7, 5, 8, 0, 0, 0, 0, 0, 0, 0},
    '{9, 1, 2, 10, 11, 12, 13, 5, 0, 0},
    '{9, 1, 14, 11, 15, 16, 17, 2, 18, 16}};
  localparam int EXP_D [6][10] = '{
    '{1, 0, 2, 1, 0, 0, 0, 0, 0, 0},
    '{1, 2, 0, 0, 0, 0, 0, 0, 0, 0},
    '{3, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 1, 2, 0, 0, 0, 0, 0, 0, 0},
    '{1, 1, 3, 1, 1, 5, 1, 0, 0, 0},
    '{1, 1, 1, 1, 1, 2, 1, 3, 1, 0}};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [OP_W-1:0] opcode = '0;
  logic [NSTB-1:0] strobe;
  logic            fetch_start, exec_start;
  int              n_chk = 0;
  int              n_bad = 0;

  always #10 clk = ~clk;

  ustep_sequencer #(
    .OP_W      (OP_W),
    .DLY_W     (4),
    .FETCH_DLY (16'h1201),
    .EXEC_DLY  ({40'h0131211111, 40'h0001511311, 40'h0000000210,
                 40'h0000000003, 40'h0000000021})
  ) dut (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .opcode      (opcode),
    .strobe      (strobe),
    .fetch_start (fetch_start),
    .exec_start  (exec_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic int gap(input int c, input int k);
    return ((EXP_D[c][k] == 0) ? 1 : EXP_D[c][k]) + 1;
  endfunction

  function automatic int lowbit(input logic [NSTB-1:0] v);
    for (int i = 0; i < NSTB; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic quiet(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk({tag, " strobes idle"}, int'(strobe), 0);
      chk({tag, " markers idle"}, int'({fetch_start, exec_start}), 0);
    end
  endtask

  task automatic wait_fetch();
    int t;
    for (t = 0; t < 60; t++) begin
      @(negedge clk);
      if (fetch_start) break;
    end
    chk("R12 fetch marker after start", int'(t < 60), 1);
  endtask

  // entered on a negedge where fetch_start is high; leaves on the next one
  task automatic run_instr(input int op, input bit alter);
    int ids [32];
    int cyc [32];
    int n = 0, xs = -1, xcnt = 0, t, ch, len;
    string tg;
    ch  = (op >= 1 && op <= 5) ? op : 0;
    len = (ch == 0) ? 0 : EXP_LEN[ch];
    tg  = (ch == 0) ? "R9" : (ch == 1) ? "R4" : (ch <= 3) ? "R5" : (ch == 4) ? "R6" : "R7";
    if (alter) tg = {tg, " R13"};
    for (int i = 0; i < 32; i++) begin ids[i] = -1; cyc[i] = -1; end
    opcode = OP_W'(op);
    for (t = 1; t <= 400; t++) begin
      @(negedge clk);
      if (fetch_start) break;
      if (exec_start) begin
        xcnt++;
        xs = t;
        if (alter) opcode = OP_W'((op % 5) + 1);
      end
      if (strobe != '0) begin
        chk("R11 single strobe", $countones(strobe), 1);
        if (n < 32) begin ids[n] = lowbit(strobe); cyc[n] = t; n++; end
      end
    end
    chk("R2 instruction completes", int'(t <= 400), 1);
    chk({tg, " strobe count"}, n, 4 + len);
    if (n != 4 + len) return;
    for (int k = 0; k < 4; k++) chk("R1 fetch order", ids[k], EXP_ID[0][k]);
    chk("R10 fetch marker lead", cyc[0], 1);
    for (int k = 0; k < 3; k++) chk("R8 R3 fetch spacing", cyc[k+1] - cyc[k], gap(0, k));
    if (ch == 0) begin
      chk("R9 no exec marker", xcnt, 0);
    end else begin
      chk("R10 exec marker count", xcnt, 1);
      chk("R2 exec after fetch", int'(xs > cyc[3]), 1);
      chk("R10 exec marker lead", cyc[4] - xs, 1);
      for (int k = 0; k < len; k++) chk({tg, " exec order"}, ids[4+k], EXP_ID[ch][k]);
      for (int k = 0; k + 1 < len; k++)
        chk("R8 R3 exec spacing", cyc[5+k] - cyc[4+k], gap(ch, k));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R12: reset state and idle until start
    repeat (3) @(negedge clk);
    quiet(2, "R12 in reset");
    rst = 1'b0;
    quiet(8, "R12 before start");
    start = 1'b1;
    wait_fetch();
    // every opcode once
    for (int op = 0; op < 16; op++) run_instr(op, 1'b0);
    // R13: opcode switched in the exec marker cycle
    for (int op = 1; op <= 5; op++) run_instr(op, 1'b1);
    // back-to-back repeats of the same chains
    run_instr(4, 1'b0); run_instr(4, 1'b0);
    run_instr(5, 1'b0); run_instr(5, 1'b0);
    run_instr(3, 1'b0); run_instr(2, 1'b0); run_instr(2, 1'b0);
    run_instr(1, 1'b0); run_instr(0, 1'b0); run_instr(1, 1'b0);
    // reset in the middle of a fetch
    repeat (3) @(negedge clk);
    rst   = 1'b1;
    start = 1'b0;
    quiet(3, "R12 mid-run reset");
    rst = 1'b0;
    quiet(10, "R12 after reset");
    start = 1'b1;
    wait_fetch();
    run_instr(5, 1'b0);
    run_instr(2, 1'b0);
    run_instr(9, 1'b0);
    summary();
  end
endmodule